// File: doc/BRIEF.md
# Wiper Position Counter with One-Hot Tap Select

This block keeps the volatile 6-bit position of one digitally controlled potentiometer wiper. It drives a 64-bit one-hot vector in which exactly one tap switch is closed. Bit 0 is the switch at the low end of the resistor string. Bit 63 is the switch at the high end. A quad device uses four copies of this block beside a shared command decoder and a bank of stored data registers.

The position can change in three ways.

- **Recall after reset.** The block starts at position 0 and waits until the value of data register 0 is offered on the recall channel. It accepts that value once and then raises its ready flag.
- **Parallel load.** The command layer loads a new position over a valid/ready channel. Both a direct write and a transfer from a selected data register arrive this way. A load is accepted in any cycle where both valid and ready are high. Ready stays low until the recall has completed, so the command layer must hold a load until ready rises.
- **Single steps.** Up and down step pulses move the wiper one segment at a time. The count stops at each end.

The recall channel has no ready signal. It is taken on the first valid cycle after reset.

Top module: `wc_wiper_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `wiper_pos` is 0, `tap_sel` has only bit 0 set, and `ready` and `ld_ready` are both low.
- R2: The first cycle with `rcl_valid` high after reset loads `rcl_data` into the position, and `ready` is high from the next cycle on.
- R3: Before `ready` is high, load requests and step pulses have no effect on the position.
- R4: Once `ready` is high, further recall offers are ignored and `ready` stays high until the next reset.
- R5: A load accepted with `ld_valid` and `ld_ready` both high sets the position to `ld_data` in the next cycle. `ld_ready` equals `ready`.
- R6: With no load present, an up pulse alone adds 1 to the position and a down pulse alone subtracts 1. Each takes effect in the next cycle.
- R7: An up pulse at 63 and a down pulse at 0 leave the position unchanged.
- R8: When a load and a step pulse arrive in the same cycle, the load value is taken and the step is dropped.
- R9: Up and down pulses together, with no load, leave the position unchanged.
- R10: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper_pos`. Index 0 is the low terminal and index 63 is the high terminal.
- R11: In a cycle with no recall, load or step, the position holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rcl_valid | input | 1 | Recall value from data register 0 is present |
| rcl_data | input | 6 | Recall value |
| ld_valid | input | 1 | Parallel load request |
| ld_ready | output | 1 | Load channel accepts requests (equal to ready) |
| ld_data | input | 6 | Parallel load value |
| step_up | input | 1 | Move one segment toward the high terminal |
| step_dn | input | 1 | Move one segment toward the low terminal |
| ready | output | 1 | Recall complete |
| wiper_pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | Registered one-hot tap switch select |

## Verification
The following are checked on every cycle by assertions:

- `tap_sel` is one-hot and its set bit matches `wiper_pos`.
- `ready` never falls after it has risen.
- The position holds while the block is waiting for recall.
- An accepted load, a single step in either direction, and the clamp at each end give the expected next position.

The bench scenarios cover what needs a planned sequence:

- A second recall offer after ready has no effect.
- A load beats a step in the same cycle.
- Up and down pulses together cancel.
- A sweep of loads over all 64 positions exercises every output of the decoder.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int WIPER_W = 6;

  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;

  function automatic move_e pick_move(input logic up, input logic dn);
    if (up && !dn)      return MV_UP;
    else if (dn && !up) return MV_DOWN;
    else                return MV_HOLD;
  endfunction
endpackage

// File: rtl/wc_step_unit.sv
module wc_step_unit #(
  parameter int POS_W = wc_pkg::WIPER_W
) (
  input  logic [POS_W-1:0] cur,
  input  logic             up,
  input  logic             dn,
  output logic [POS_W-1:0] nxt
);
  import wc_pkg::*;
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  move_e mv;

  always_comb begin
    mv  = pick_move(up, dn);
    nxt = cur;
    unique case (mv)
      MV_UP:   if (cur != POS_MAX) nxt = cur + 1'b1;
      MV_DOWN: if (cur != POS_MIN) nxt = cur - 1'b1;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/wc_tap_decode.sv
module wc_tap_decode #(
  parameter int POS_W = wc_pkg::WIPER_W,
  localparam int TAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] idx,
  output logic [TAPS-1:0]  onehot
);
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign onehot[g] = (idx == POS_W'(g));
  end
endmodule

// File: rtl/wc_wiper_counter.sv
module wc_wiper_counter #(
  parameter int POS_W = wc_pkg::WIPER_W,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rcl_valid,
  input  logic [POS_W-1:0] rcl_data,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [POS_W-1:0] ld_data,
  input  logic             step_up,
  input  logic             step_dn,
  output logic             ready,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_sel
);
  logic [POS_W-1:0] pos_q, pos_d, stepped;
  logic             rdy_q, rdy_d;
  logic [TAPS-1:0]  tap_d, tap_q;

  wc_step_unit #(.POS_W(POS_W)) step_i (
    .cur (pos_q),
    .up  (step_up),
    .dn  (step_dn),
    .nxt (stepped)
  );

  // Select the next position. Recall is taken only before ready.
  // After ready, a load beats a step.
  always_comb begin
    pos_d = pos_q;
    rdy_d = rdy_q;
    if (!rdy_q) begin
      if (rcl_valid) begin
        pos_d = rcl_data;
        rdy_d = 1'b1;
      end
    end else if (ld_valid) begin
      pos_d = ld_data;
    end else begin
      pos_d = stepped;
    end
  end

  // Decode the next position so that the switch vector is a register.
  wc_tap_decode #(.POS_W(POS_W)) dec_i (
    .idx    (pos_d),
    .onehot (tap_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      rdy_q <= 1'b0;
      tap_q <= TAPS'(1);
    end else begin
      pos_q <= pos_d;
      rdy_q <= rdy_d;
      tap_q <= tap_d;
    end
  end

  assign wiper_pos = pos_q;
  assign ready     = rdy_q;
  assign ld_ready  = rdy_q;
  assign tap_sel   = tap_q;
endmodule

// File: rtl/wc_wiper_counter_chk.sv
module wc_wiper_counter_chk #(
  parameter int POS_W = wc_pkg::WIPER_W,
  localparam int TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rcl_valid,
  input logic [POS_W-1:0] rcl_data,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic [POS_W-1:0] ld_data,
  input logic             step_up,
  input logic             step_dn,
  input logic             ready,
  input logic [POS_W-1:0] wiper_pos,
  input logic [TAPS-1:0]  tap_sel
);
  localparam logic [POS_W-1:0] PMAX = {POS_W{1'b1}};

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  p_tap_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[wiper_pos]);

  p_recall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && rcl_valid) |=> (ready && wiper_pos == $past(rcl_data)));

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !rcl_valid) |=> $stable(wiper_pos));

  p_ready_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> wiper_pos == $past(ld_data));

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ld_valid && step_up && !step_dn && wiper_pos != PMAX)
      |=> wiper_pos == $past(wiper_pos) + 1'b1);

  p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ld_valid && step_dn && !step_up && wiper_pos != '0)
      |=> wiper_pos == $past(wiper_pos) - 1'b1);

  p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ld_valid && step_up && wiper_pos == PMAX) |=> wiper_pos == PMAX);

  p_sat_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ld_valid && step_dn && wiper_pos == '0) |=> wiper_pos == '0);
endmodule

bind wc_wiper_counter wc_wiper_counter_chk #(.POS_W(POS_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rcl_valid (rcl_valid),
  .rcl_data  (rcl_data),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .ld_data   (ld_data),
  .step_up   (step_up),
  .step_dn   (step_dn),
  .ready     (ready),
  .wiper_pos (wiper_pos),
  .tap_sel   (tap_sel)
);

// File: tb/wc_wiper_counter_tb.sv
module wc_wiper_counter_tb_top;
  localparam int W = 6;
  localparam int T = 64;

  typedef struct {
    logic [W-1:0] pos;
    logic         rdy;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rcl_valid = 1'b0;
  logic [W-1:0] rcl_data = '0;
  logic         ld_valid = 1'b0;
  logic         ld_ready;
  logic [W-1:0] ld_data = '0;
  logic         step_up = 1'b0;
  logic         step_dn = 1'b0;
  logic         ready;
  logic [W-1:0] wiper_pos;
  logic [T-1:0] tap_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  exp_t sb_q[$];

  logic [W-1:0] m_pos = '0;
  logic         m_rdy = 1'b0;

  always #4 clk = ~clk;

  wc_wiper_counter dut_i (
    .clk(clk), .rst_n(rst_n), .rcl_valid(rcl_valid), .rcl_data(rcl_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .step_up(step_up), .step_dn(step_dn), .ready(ready),
    .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  task automatic check_now(string tag, logic [W-1:0] ep, logic er);
    logic [T-1:0] et;
    et = T'(1) << ep;
    n_tests++;
    if (wiper_pos !== ep || tap_sel !== et || ready !== er || ld_ready !== er) begin
      n_fail++;
      $display("FAIL %s: pos=%0d tap=%h rdy=%b ld_rdy=%b expected pos=%0d tap=%h rdy=%b",
               tag, wiper_pos, tap_sel, ready, ld_ready, ep, et, er);
    end
  endtask

  // Driver: drives one cycle of stimulus and pushes the expected result.
  task automatic drive(string tag, logic rv, logic [W-1:0] rd, logic lv,
                       logic [W-1:0] ld, logic up, logic dn);
    exp_t e;
    @(negedge clk);
    rcl_valid = rv; rcl_data = rd; ld_valid = lv; ld_data = ld;
    step_up = up; step_dn = dn;
    if (!m_rdy) begin
      if (rv) begin m_pos = rd; m_rdy = 1'b1; end
    end else if (lv) begin
      m_pos = ld;
    end else if (up && !dn) begin
      if (m_pos != 6'd63) m_pos = m_pos + 1'b1;
    end else if (dn && !up) begin
      if (m_pos != 6'd0) m_pos = m_pos - 1'b1;
    end
    e.pos = m_pos; e.rdy = m_rdy; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares shortly after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check_now(e.tag, e.pos, e.rdy);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now("R1 reset", 6'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check_now("R1 after reset", 6'd0, 1'b0);
    drive("R3 load before ready", 0, 0, 1, 6'd40, 0, 0);
    drive("R3 step before ready", 0, 0, 0, 0, 1, 0);
    drive("R11 idle waiting", 0, 0, 0, 0, 0, 0);
    drive("R2 recall", 1, 6'd5, 0, 0, 0, 0);
    drive("R4 second recall ignored", 1, 6'd9, 0, 0, 0, 0);
    drive("R6 up", 0, 0, 0, 0, 1, 0);
    drive("R6 down", 0, 0, 0, 0, 0, 1);
    drive("R5 load 62", 0, 0, 1, 6'd62, 0, 0);
    drive("R6 up to 63", 0, 0, 0, 0, 1, 0);
    drive("R7 up at top", 0, 0, 0, 0, 1, 0);
    drive("R5 load 0", 0, 0, 1, 6'd0, 0, 0);
    drive("R7 down at bottom", 0, 0, 0, 0, 0, 1);
    drive("R8 load beats up", 0, 0, 1, 6'd10, 1, 0);
    drive("R8 load beats down", 0, 0, 1, 6'd33, 0, 1);
    drive("R9 up and down", 0, 0, 0, 0, 1, 1);
    drive("R11 idle", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < T; i++) drive("R10 decode sweep", 0, 0, 1, W'(i), 0, 0);
    drive("R11 idle end", 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule